// File: doc/BRIEF.md
# Interrupt Controller Initialization Sequencer

This block is the write-side front end of a classic eight-input programmable interrupt controller. It watches byte writes to two adjacent I/O addresses: a command address, which is the base, and a data address, which is the base plus one. A chip places two instances, one for the primary controller and one for the secondary, each with its own base address. A command-address write with bit 4 set is the first initialization word. It restarts the controller's setup from any state, returns the controller's mode state to known defaults, and arms a short sequence in which the next three data-address writes are captured as the second, third and fourth initialization words.

The captured words, the interrupt mask, the lowest-priority line, the cascade address, the special-mask flag and the status-read select go out to the rest of the controller. This block is only the front end: arbitration and vector delivery happen elsewhere. The hardware only supports cascaded operation with the fourth word present, so a first word that asks for anything else raises a sticky error flag instead of changing the behaviour. Until the fourth word lands, the block reports itself as not initialized, and mask writes have no effect.

Top module: `pic_init_seq`

## Requirements
- R1: After reset, irqMask is 0x00, lowPrioLine is 7, cascadeAddr is 7, specialMask is 0, statusSelIsr is 0, the three stored words are 0x00, and initDone and progErr are 0.
- R2: A write to BASE_ADDR with wrData bit 4 = 1 restarts the sequence from any state. From the next clock edge, irqMask is 0x00, lowPrioLine is 7, cascadeAddr is 7, specialMask is 0, statusSelIsr is 0 (request register selected) and initDone is 0.
- R3: After that write, the next three writes to BASE_ADDR+1 are stored in order into vecWord, cascWord and modeWord. initDone becomes 1 on the edge that stores the third of them.
- R4: Writes to any address other than BASE_ADDR and BASE_ADDR+1, and writes to BASE_ADDR with bit 4 = 0, do not advance the sequence and do not change any output.
- R5: When cascWord is stored, its bits 2:0 become cascadeAddr.
- R6: A first word with bit 1 = 1 (single mode) or bit 0 = 0 (fourth word not required) sets progErr on the next edge. The sequence still restarts, and the block still waits for three data words.
- R7: progErr stays set until a first word arrives with bit 1 = 0 and bit 0 = 1. That word clears it on the next edge. No other write changes progErr.
- R8: Bit 3 of the first word (level-trigger select) has no effect: it neither sets progErr nor alters the sequence.
- R9: While initDone is 1 and no sequence is in progress, a write to BASE_ADDR+1 loads wrData into irqMask on the next edge. While initDone is 0, irqMask holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Byte write strobe, one cycle per write |
| wrAddr | input | ADDR_W | I/O address of the write |
| wrData | input | 8 | Write data byte |
| irqMask | output | 8 | Interrupt mask, one bit per input line |
| lowPrioLine | output | 3 | Input line that currently has the lowest priority |
| cascadeAddr | output | 3 | Cascade / slave address |
| specialMask | output | 1 | Special mask mode flag |
| statusSelIsr | output | 1 | Status-read select: 0 selects request register, 1 selects in-service register |
| vecWord | output | 8 | Stored second initialization word |
| cascWord | output | 8 | Stored third initialization word |
| modeWord | output | 8 | Stored fourth initialization word |
| initDone | output | 1 | High once the fourth word is stored |
| progErr | output | 1 | Sticky flag for an unsupported first-word setting |

## Verification
If the step counter is in the wrong state, the stored words shift by one position, or cascadeAddr and initDone change one data write early or late. This shows up at the ports on the edge after the misplaced write. A wrong mask-lock state shows up as an irqMask that moves, or fails to move, one cycle after a data-address write. An error flag that is not sticky enough, or too sticky, shows up on progErr on the edge after the first word that follows.

// File: rtl/pic_init_pkg.sv
package pic_init_pkg;

  localparam int WORD_W = 8;

  // Which initialization word is expected next
  typedef enum logic [2:0] {
    STEP_IDLE = 3'd0,
    STEP_W2   = 3'd1,
    STEP_W3   = 3'd2,
    STEP_W4   = 3'd3
  } stepT;

  // Strobes from control to datapath
  typedef struct packed {
    logic restart;
    logic badCfg;
    logic ld2;
    logic ld3;
    logic ld4;
    logic ldMask;
  } strobeT;

endpackage

// File: rtl/pic_init_ctrl.sv
module pic_init_ctrl
  import pic_init_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       isCmd,
  input  logic       isData,
  input  logic [2:0] cmdBits,   // {bit4, bit1, bit0} of the written byte
  output strobeT     stb,
  output logic       initDone
);

  stepT step;
  logic firstWord;

  assign firstWord = wrEn && isCmd && cmdBits[2];

  always_comb begin
    stb = '0;
    if (firstWord) begin
      stb.restart = 1'b1;
      stb.badCfg  = cmdBits[1] | ~cmdBits[0];
    end else if (wrEn && isData) begin
      unique case (step)
        STEP_W2: stb.ld2 = 1'b1;
        STEP_W3: stb.ld3 = 1'b1;
        STEP_W4: stb.ld4 = 1'b1;
        default: stb.ldMask = initDone;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      step     <= STEP_IDLE;
      initDone <= 1'b0;
    end else if (stb.restart) begin
      step     <= STEP_W2;
      initDone <= 1'b0;
    end else if (stb.ld2) begin
      step <= STEP_W3;
    end else if (stb.ld3) begin
      step <= STEP_W4;
    end else if (stb.ld4) begin
      step     <= STEP_IDLE;
      initDone <= 1'b1;
    end
  end

endmodule

// File: rtl/pic_init_dp.sv
module pic_init_dp
  import pic_init_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            stb,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] irqMask,
  output logic [2:0]        lowPrioLine,
  output logic [2:0]        cascadeAddr,
  output logic              specialMask,
  output logic              statusSelIsr,
  output logic [WORD_W-1:0] vecWord,
  output logic [WORD_W-1:0] cascWord,
  output logic [WORD_W-1:0] modeWord,
  output logic              progErr
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqMask      <= '0;
      lowPrioLine  <= 3'd7;
      cascadeAddr  <= 3'd7;
      specialMask  <= 1'b0;
      statusSelIsr <= 1'b0;
      vecWord      <= '0;
      cascWord     <= '0;
      modeWord     <= '0;
      progErr      <= 1'b0;
    end else begin
      if (stb.restart) begin
        irqMask      <= '0;
        lowPrioLine  <= 3'd7;
        cascadeAddr  <= 3'd7;
        specialMask  <= 1'b0;
        statusSelIsr <= 1'b0;
        progErr      <= stb.badCfg;
      end
      if (stb.ld2) vecWord <= wrData;
      if (stb.ld3) begin
        cascWord    <= wrData;
        cascadeAddr <= wrData[2:0];
      end
      if (stb.ld4)    modeWord <= wrData;
      if (stb.ldMask) irqMask  <= wrData;
    end
  end

endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_init_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0020
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  output logic [7:0]        irqMask,
  output logic [2:0]        lowPrioLine,
  output logic [2:0]        cascadeAddr,
  output logic              specialMask,
  output logic              statusSelIsr,
  output logic [7:0]        vecWord,
  output logic [7:0]        cascWord,
  output logic [7:0]        modeWord,
  output logic              initDone,
  output logic              progErr
);

  localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR + 1'b1;

  strobeT stb;
  logic   isCmd, isData;

  assign isCmd  = (wrAddr == BASE_ADDR);
  assign isData = (wrAddr == DATA_ADDR);

  pic_init_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .isCmd    (isCmd),
    .isData   (isData),
    .cmdBits  ({wrData[4], wrData[1], wrData[0]}),
    .stb      (stb),
    .initDone (initDone)
  );

  pic_init_dp u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .wrData       (wrData),
    .irqMask      (irqMask),
    .lowPrioLine  (lowPrioLine),
    .cascadeAddr  (cascadeAddr),
    .specialMask  (specialMask),
    .statusSelIsr (statusSelIsr),
    .vecWord      (vecWord),
    .cascWord     (cascWord),
    .modeWord     (modeWord),
    .progErr      (progErr)
  );

endmodule

// File: rtl/pic_init_seq_chk.sv
module pic_init_seq_chk #(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0020
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [7:0]        wrData,
  input logic [7:0]        irqMask,
  input logic [2:0]        lowPrioLine,
  input logic [2:0]        cascadeAddr,
  input logic              specialMask,
  input logic              statusSelIsr,
  input logic              initDone,
  input logic              progErr
);

  localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR + 1'b1;

  logic cmdHit, dataHit, goodFirst;
  assign cmdHit    = wrEn && (wrAddr == BASE_ADDR) && wrData[4];
  assign dataHit   = wrEn && (wrAddr == DATA_ADDR);
  assign goodFirst = !wrData[1] && wrData[0];

  AST_FIRST_WORD_DEFAULTS: assert property (@(posedge clk) disable iff (!rstN)
    cmdHit |=> (irqMask == 8'h00) && (lowPrioLine == 3'd7) && (cascadeAddr == 3'd7)
               && !specialMask && !statusSelIsr && !initDone); // R2

  AST_BAD_CFG_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (cmdHit && !goodFirst) |=> progErr); // R6

  AST_GOOD_CFG_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (cmdHit && goodFirst) |=> !progErr); // R7

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !cmdHit |=> $stable(progErr)); // R7

  AST_MASK_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    !initDone |=> $stable(irqMask)); // R9

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (initDone && dataHit) |=> (irqMask == $past(wrData))); // R9

  AST_DONE_ON_DATA: assert property (@(posedge clk) disable iff (!rstN)
    $rose(initDone) |-> $past(dataHit)); // R3

endmodule

bind pic_init_seq pic_init_seq_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .wrEn         (wrEn),
  .wrAddr       (wrAddr),
  .wrData       (wrData),
  .irqMask      (irqMask),
  .lowPrioLine  (lowPrioLine),
  .cascadeAddr  (cascadeAddr),
  .specialMask  (specialMask),
  .statusSelIsr (statusSelIsr),
  .initDone     (initDone),
  .progErr      (progErr)
);

// File: tb/pic_init_seq_bench.sv
module pic_init_seq_bench;

  localparam logic [15:0] BASE  = 16'h0020;
  localparam logic [15:0] OTHER = 16'h0050;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  irqMask, vecWord, cascWord, modeWord;
  logic [2:0]  lowPrioLine, cascadeAddr;
  logic        specialMask, statusSelIsr, initDone, progErr;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pic_init_seq #(.ADDR_W(16), .BASE_ADDR(BASE)) u_pic_init_seq (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .irqMask(irqMask), .lowPrioLine(lowPrioLine), .cascadeAddr(cascadeAddr),
    .specialMask(specialMask), .statusSelIsr(statusSelIsr),
    .vecWord(vecWord), .cascWord(cascWord), .modeWord(modeWord),
    .initDone(initDone), .progErr(progErr)
  );

  // Row: {op[1:0] (0 command, 1 data, 2 other address), data, expMask, expDone, expErr, expCasc}
  localparam int NV = 18;
  localparam logic [22:0] VEC [NV] = '{
    {2'd0, 8'h11, 8'h00, 1'b0, 1'b0, 3'd7}, // R2 valid first word
    {2'd1, 8'h40, 8'h00, 1'b0, 1'b0, 3'd7}, // R3 word 2
    {2'd1, 8'h05, 8'h00, 1'b0, 1'b0, 3'd5}, // R5 word 3
    {2'd1, 8'h01, 8'h00, 1'b1, 1'b0, 3'd5}, // R3 word 4
    {2'd1, 8'hA5, 8'hA5, 1'b1, 1'b0, 3'd5}, // R9 mask load
    {2'd0, 8'h08, 8'hA5, 1'b1, 1'b0, 3'd5}, // R4 bit4 clear ignored
    {2'd0, 8'h13, 8'h00, 1'b0, 1'b1, 3'd7}, // R6 single mode
    {2'd1, 8'h3C, 8'h00, 1'b0, 1'b1, 3'd7}, // R6 sequence still runs
    {2'd1, 8'h02, 8'h00, 1'b0, 1'b1, 3'd2},
    {2'd1, 8'h01, 8'h00, 1'b1, 1'b1, 3'd2}, // R7 still sticky
    {2'd1, 8'hFF, 8'hFF, 1'b1, 1'b1, 3'd2},
    {2'd0, 8'h10, 8'h00, 1'b0, 1'b1, 3'd7}, // R6 fourth word not required
    {2'd0, 8'h19, 8'h00, 1'b0, 1'b0, 3'd7}, // R7 R8 valid with level bit
    {2'd2, 8'h77, 8'h00, 1'b0, 1'b0, 3'd7}, // R4 other address
    {2'd1, 8'h48, 8'h00, 1'b0, 1'b0, 3'd7},
    {2'd1, 8'h07, 8'h00, 1'b0, 1'b0, 3'd7},
    {2'd1, 8'h03, 8'h00, 1'b1, 1'b0, 3'd7}, // R8 sequence unaffected
    {2'd2, 8'h11, 8'h00, 1'b1, 1'b0, 3'd7}  // R4 other address
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irqMask", irqMask, 8'h00);
    check("R1 lowPrioLine", lowPrioLine, 3'd7);
    check("R1 cascadeAddr", cascadeAddr, 3'd7);
    check("R1 specialMask/statusSelIsr", {specialMask, statusSelIsr}, 2'b00);
    check("R1 words", {vecWord, cascWord, modeWord}, 24'h0);
    check("R1 initDone/progErr", {initDone, progErr}, 2'b00);

    // R9 mask write before initialization is ignored
    doWrite(BASE + 16'd1, 8'h5A);
    check("R9 mask locked", irqMask, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [15:0] a;
      op = VEC[i][22:21];
      a  = (op == 2'd0) ? BASE : (op == 2'd1) ? BASE + 16'd1 : OTHER;
      doWrite(a, VEC[i][20:13]);
      check($sformatf("row %0d R2 R9 mask", i), irqMask, VEC[i][12:5]);
      check($sformatf("row %0d R3 initDone", i), initDone, VEC[i][4]);
      check($sformatf("row %0d R6 R7 progErr", i), progErr, VEC[i][3]);
      check($sformatf("row %0d R5 cascadeAddr", i), cascadeAddr, VEC[i][2:0]);
    end
    // R3 stored words of the last sequence
    check("R3 vecWord", vecWord, 8'h48);
    check("R3 cascWord", cascWord, 8'h07);
    check("R3 modeWord", modeWord, 8'h03);
    check("R2 statusSelIsr/specialMask/lowPrioLine", {statusSelIsr, specialMask, lowPrioLine}, 5'b00111);

    // R2 restart in the middle of a sequence
    doWrite(BASE, 8'h11);
    doWrite(BASE + 16'd1, 8'hAA);
    doWrite(BASE, 8'h11);
    check("R2 restart clears initDone", initDone, 1'b0);
    doWrite(BASE + 16'd1, 8'h60);
    doWrite(BASE + 16'd1, 8'h04);
    check("R2 not done after two words", initDone, 1'b0);
    doWrite(BASE, 8'h0B);                 // R4 bit4 clear, no advance
    check("R4 cascWord unchanged", cascWord, 8'h04);
    doWrite(BASE + 16'd1, 8'h1D);
    check("R2 vecWord after restart", vecWord, 8'h60);
    check("R5 cascadeAddr", cascadeAddr, 3'd4);
    check("R3 modeWord", modeWord, 8'h1D);
    check("R3 initDone", initDone, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule